// File: doc/BRIEF.md
# I2C Register Target with Transmit-Queue Back-Pressure

This block is the I2C target side of a serial peripheral. A host on the two-wire bus uses it to reach the peripheral's register file and to load bytes into its transmit queue. SCL and SDA are oversampled by the system clock through a synchronizer, and bus events are derived from the synchronized levels. The block answers one fixed 7-bit target address, which is set by a parameter. The byte after the address in a write selects an internal register. Each following data byte becomes a one-cycle write strobe on a simple register bus.

Reads use the usual combined format. The host writes the register number, issues a repeated START, then sends the address with the read bit. The block then shifts out register contents for as long as the host keeps acknowledging. One register number is reserved as the transmit-queue entry. A byte sent to it while the queue reports full is refused with a NACK and is not written. The sub-address does not advance on that register, so a burst of bytes all land in the queue.

The block only drives an open-drain pull-down enable for SDA. It never holds SCL low to stretch the clock.

Top module: `i2c_reg_target`

## Requirements
- R1: SDA falling while SCL is high is a START. From any state, a START aborts the current activity and begins reception of a new address byte.
- R2: SDA rising while SCL is high is a STOP. A STOP releases SDA and returns the block to idle. Bits clocked after a STOP and before the next START get no acknowledge and produce no register strobe.
- R3: The first byte after a START is the 7-bit address, MSB first, followed by a direction bit (0 = write, 1 = read). A matching address is acknowledged by pulling SDA low for the ninth clock.
- R4: When the address does not match, the SDA enable is never asserted and no register strobe is issued until the next START or STOP.
- R5: In a write, the byte after the address sets the sub-address (`reg_addr`) and is acknowledged. Each later data byte gives a one-cycle `reg_wr` pulse, with `reg_addr` and `reg_wdata` valid in that cycle. `reg_wr` and `reg_rd` are never high together.
- R6: After each written or read byte, the sub-address increments by one, except when it equals the transmit-queue register (parameter FIFO_ADDR, default 0x00). In that case it stays put, so a burst goes to the queue.
- R7: If a data byte is addressed to FIFO_ADDR and `fifo_full` is high when its eighth bit completes, the byte gets a NACK (SDA left high) and no `reg_wr` pulse. Writes to other registers are acknowledged regardless of `fifo_full`.
- R8: In a read, the block captures `reg_rdata` in a cycle where `reg_rd` is high and drives it MSB first. Each SDA change happens after an SCL fall. A host ACK loads the next register.
- R9: After the host NACKs a read byte, the block releases SDA and does not drive it again until a START or STOP.
- R10: The SDA enable changes only while synchronized SCL is low.
- R11: After reset, the SDA enable, `reg_wr` and `reg_rd` are low and `reg_addr` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle read strobe; reg_rdata is sampled in this cycle |
| reg_addr | output | 8 | Current register sub-address |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_rdata | input | 8 | Read data for reg_addr |
| fifo_full | input | 1 | Transmit queue cannot take another byte |

## Verification
The hardest case to reach is `fifo_full` changing partway through a burst of writes to the queue register. Only the affected byte may be refused, and the bytes before and after it must still be acknowledged and written. The bench reaches this by keeping one write transaction open and toggling `fifo_full` between data bytes, then counting queue writes. A second hard case is the quiet state after a refused address, a read NACK or a STOP. The bench reaches it by clocking whole bytes without a START and checking that the SDA enable never rose. A START inserted in the middle of a byte covers the abort path.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } tgt_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_SUB,
    K_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff_q, sda_ff_q;
  logic [SYNC_STAGES-1:0] scl_ff_d, sda_ff_d;
  logic scl_prev_q, sda_prev_q;

  // synchronizer chain, one stage per generate iteration
  assign scl_ff_d[0] = scl_i;
  assign sda_ff_d[0] = sda_i;
  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    assign scl_ff_d[g] = scl_ff_q[g-1];
    assign sda_ff_d[g] = sda_ff_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff_q   <= '1;
      sda_ff_q   <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_ff_q   <= scl_ff_d;
      sda_ff_q   <= sda_ff_d;
      scl_prev_q <= scl_lvl;
      sda_prev_q <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_ff_q[SYNC_STAGES-1];
  assign sda_lvl   = sda_ff_q[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev_q;
  assign scl_fall  = ~scl_lvl & scl_prev_q;
  assign start_det = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR  = 7'h2A,
  parameter int         AW        = 8,
  parameter int         DW        = 8,
  parameter logic [AW-1:0] FIFO_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          fifo_full,
  input  logic [DW-1:0] reg_rdata,
  output logic          sda_oe,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW);

  tgt_state_e state_q, state_d;
  byte_kind_e kind_q, kind_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DW-1:0] shreg_q, shreg_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic [AW-1:0] addr_q, addr_d;
  logic oe_q, oe_d;
  logic wr_q, wr_d;
  logic rw_q, rw_d;
  logic mnack_q, mnack_d;
  logic inc_q, inc_d;
  logic rd_pulse;
  logic addr_hit;
  logic on_fifo;

  assign addr_hit = (shreg_q[DW-1:DW-7] == TGT_ADDR);
  assign on_fifo  = (addr_q == FIFO_ADDR);

  // next-state logic
  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    wdata_d  = wdata_q;
    addr_d   = addr_q;
    oe_d     = oe_q;
    wr_d     = 1'b0;
    rw_d     = rw_q;
    mnack_d  = mnack_q;
    inc_d    = inc_q;
    rd_pulse = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      inc_d   = 1'b0;
    end else if (start_det) begin
      state_d = ST_RX;
      kind_d  = K_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
      inc_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && cnt_q != LAST_BIT) begin
            shreg_d = {shreg_q[DW-2:0], sda_lvl};
            cnt_d   = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            unique case (kind_q)
              K_ADDR: begin
                if (addr_hit) begin
                  rw_d    = shreg_q[0];
                  oe_d    = 1'b1;
                  state_d = ST_RX_ACK;
                end else begin
                  state_d = ST_IGNORE;
                end
              end
              K_SUB: begin
                addr_d  = shreg_q[AW-1:0];
                oe_d    = 1'b1;
                state_d = ST_RX_ACK;
              end
              default: begin
                state_d = ST_RX_ACK;
                if (on_fifo && fifo_full) begin
                  oe_d = 1'b0;
                end else begin
                  oe_d    = 1'b1;
                  wr_d    = 1'b1;
                  wdata_d = shreg_q;
                  inc_d   = !on_fifo;
                end
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            oe_d  = 1'b0;
            cnt_d = '0;
            inc_d = 1'b0;
            if (inc_q) addr_d = addr_q + 1'b1;
            unique case (kind_q)
              K_ADDR: begin
                if (rw_q) begin
                  rd_pulse = 1'b1;
                  shreg_d  = reg_rdata;
                  oe_d     = ~reg_rdata[DW-1];
                  state_d  = ST_TX;
                end else begin
                  kind_d  = K_SUB;
                  state_d = ST_RX;
                end
              end
              default: begin
                kind_d  = K_DATA;
                state_d = ST_RX;
              end
            endcase
          end
        end
        ST_TX: begin
          if (scl_rise && cnt_q != LAST_BIT) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              oe_d    = 1'b0;
              state_d = ST_TX_ACK;
              if (!on_fifo) addr_d = addr_q + 1'b1;
            end else begin
              shreg_d = {shreg_q[DW-2:0], 1'b0};
              oe_d    = ~shreg_q[DW-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mnack_d = sda_lvl;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (!mnack_q) begin
              rd_pulse = 1'b1;
              shreg_d  = reg_rdata;
              oe_d     = ~reg_rdata[DW-1];
              state_d  = ST_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_IGNORE;
            end
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_ADDR;
      cnt_q   <= '0;
      shreg_q <= '0;
      wdata_q <= '0;
      addr_q  <= '0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
      rw_q    <= 1'b0;
      mnack_q <= 1'b1;
      inc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      wdata_q <= wdata_d;
      addr_q  <= addr_d;
      oe_q    <= oe_d;
      wr_q    <= wr_d;
      rw_q    <= rw_d;
      mnack_q <= mnack_d;
      inc_q   <= inc_d;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_wr    = wr_q;
  assign reg_rd    = rd_pulse;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;

  // assertions
  p_start_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state_q == ST_RX && cnt_q == '0 && kind_q == K_ADDR));

  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !oe_q));

  p_ignore_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> (!oe_q && !wr_q && !rd_pulse));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_q, rd_pulse}));

  p_no_full_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && addr_q == FIFO_ADDR) |-> !$past(fifo_full));

  p_fifo_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && addr_q == FIFO_ADDR) |=> (addr_q == FIFO_ADDR));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] TGT_ADDR    = 7'h2A,
  parameter logic [7:0] FIFO_ADDR   = 8'h00,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       reg_wr,
  output logic       reg_rd,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata,
  input  logic       fifo_full
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_ctrl #(
    .TGT_ADDR  (TGT_ADDR),
    .AW        (8),
    .DW        (8),
    .FIFO_ADDR (FIFO_ADDR)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .fifo_full (fifo_full),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
  );

  // SDA enable may only move while SCL is seen low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_lvl));
endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam int Q = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic scl_m, sda_m;
  logic sda_oe, reg_wr, reg_rd, fifo_full;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire sda_bus = sda_m & ~sda_oe;

  logic [7:0] mem [256];
  int wr_count = 0, rd_count = 0, fifo_count = 0, oe_hi = 0, oe_bad = 0;
  logic oe_prev = 1'b0;
  int n_checks = 0, n_err = 0;
  bit finished = 0;

  i2c_reg_target i_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_full(fifo_full)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
      wr_count <= wr_count + 1;
      if (reg_addr == 8'h00) fifo_count <= fifo_count + 1;
    end
    if (reg_rd) rd_count <= rd_count + 1;
  end

  // R10 monitor: enable must not move while the raw SCL is high
  always @(negedge clk) begin
    if (sda_oe) oe_hi <= oe_hi + 1;
    if (rst_n && sda_oe !== oe_prev && scl_m) oe_bad <= oe_bad + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = (sda_bus == 1'b0);
    wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic get_byte(input logic host_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      d[i] = sda_bus;
      wq(Q);
      scl_m = 1'b0; wq(Q);
    end
    put_bit(~host_ack);
    sda_m = 1'b1;
  endtask

  typedef struct packed {
    logic [6:0] adr;
    logic [7:0] sub;
    logic [7:0] dat;
    logic       full;
    logic       e_aack;
    logic       e_dack;
    logic       e_wr;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{7'h2A, 8'h10, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b1},
    '{7'h2A, 8'h00, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b1},
    '{7'h2A, 8'h00, 8'h77, 1'b1, 1'b1, 1'b0, 1'b0},
    '{7'h2A, 8'h22, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b1},
    '{7'h15, 8'h40, 8'h99, 1'b0, 1'b0, 1'b0, 1'b0},
    '{7'h2A, 8'hFF, 8'h01, 1'b0, 1'b1, 1'b1, 1'b1},
    '{7'h2B, 8'h41, 8'h98, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5C);
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; fifo_full = 1'b0;
    wq(10);
    chk("R11 sda_oe", sda_oe, 0);
    chk("R11 reg_wr", reg_wr, 0);
    chk("R11 reg_rd", reg_rd, 0);
    chk("R11 reg_addr", reg_addr, 0);
    rst_n = 1'b1;
    wq(10);

    // table walk: single-byte writes
    for (int v = 0; v < 7; v++) begin
      logic ack;
      int wc, oh;
      fifo_full = VEC[v].full;
      wc = wr_count;
      oh = oe_hi;
      bus_start();
      send_byte({VEC[v].adr, 1'b0}, ack);
      chk("R3/R4 address ack", ack, VEC[v].e_aack);
      send_byte(VEC[v].sub, ack);
      if (VEC[v].e_aack) chk("R5 sub-address ack", ack, 1);
      send_byte(VEC[v].dat, ack);
      chk("R7 data ack", ack, VEC[v].e_dack);
      bus_stop();
      chk("R5/R7 write count", wr_count - wc, VEC[v].e_wr ? 1 : 0);
      if (VEC[v].e_wr) chk("R5 written value", mem[VEC[v].sub], VEC[v].dat);
      if (!VEC[v].e_aack) chk("R4 enable never set", oe_hi - oh, 0);
    end
    fifo_full = 1'b0;

    // R6: auto-increment on ordinary registers
    begin
      logic ack;
      bus_start();
      send_byte({7'h2A, 1'b0}, ack);
      send_byte(8'h30, ack);
      send_byte(8'h11, ack);
      send_byte(8'h22, ack);
      send_byte(8'h33, ack);
      bus_stop();
      chk("R6 mem30", mem[8'h30], 8'h11);
      chk("R6 mem31", mem[8'h31], 8'h22);
      chk("R6 mem32", mem[8'h32], 8'h33);
      chk("R6 addr advanced", reg_addr, 8'h33);
    end

    // R6/R7: queue burst with full toggled mid-transaction
    begin
      logic ack;
      int fc;
      fc = fifo_count;
      bus_start();
      send_byte({7'h2A, 1'b0}, ack);
      send_byte(8'h00, ack);
      send_byte(8'h01, ack);
      chk("R6 queue byte1 ack", ack, 1);
      send_byte(8'h02, ack);
      fifo_full = 1'b1;
      send_byte(8'h03, ack);
      chk("R7 full mid-burst nack", ack, 0);
      fifo_full = 1'b0;
      send_byte(8'h04, ack);
      chk("R7 after release ack", ack, 1);
      bus_stop();
      chk("R6 queue pushes", fifo_count - fc, 3);
      chk("R6 addr stays on queue", reg_addr, 8'h00);
      chk("R7 last queue byte", mem[8'h00], 8'h04);
    end

    // R8/R9: combined read with repeated START
    begin
      logic ack;
      logic [7:0] d0, d1;
      int rc, oh;
      rc = rd_count;
      bus_start();
      send_byte({7'h2A, 1'b0}, ack);
      send_byte(8'h30, ack);
      bus_start();
      send_byte({7'h2A, 1'b1}, ack);
      chk("R3 read address ack", ack, 1);
      get_byte(1'b1, d0);
      get_byte(1'b0, d1);
      chk("R8 read byte0", d0, 8'h11);
      chk("R8 read byte1", d1, 8'h22);
      chk("R8 read strobes", rd_count - rc, 2);
      oh = oe_hi;
      for (int i = 0; i < 9; i++) put_bit(1'b1);
      chk("R9 silent after host nack", oe_hi - oh, 0);
      bus_stop();
    end

    // R2: clocking without START after STOP
    begin
      int wc, oh;
      wc = wr_count;
      oh = oe_hi;
      scl_m = 1'b0; wq(Q);
      for (int i = 0; i < 8; i++) put_bit(i[0]);
      put_bit(1'b1);
      for (int i = 0; i < 9; i++) put_bit(1'b1);
      chk("R2 no ack after stop", oe_hi - oh, 0);
      chk("R2 no write after stop", wr_count - wc, 0);
      sda_m = 1'b1; scl_m = 1'b1; wq(2*Q);
    end

    // R1: START in the middle of a byte restarts cleanly
    begin
      logic ack;
      bus_start();
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
      bus_start();
      send_byte({7'h2A, 1'b0}, ack);
      chk("R1 address ack after restart", ack, 1);
      send_byte(8'h50, ack);
      send_byte(8'h6E, ack);
      bus_stop();
      chk("R1 write after restart", mem[8'h50], 8'h6E);
    end

    chk("R10 enable moved while SCL high", oe_bad, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule